// File: doc/BRIEF.md
# Logic Tile with Ripple Carry Chain

The block is one logic tile of a programmable fabric. It holds eight cells, and each cell pairs a 4-input lookup table with a dedicated carry unit. The carry units form a ripple chain from cell 0 up to cell 7. The carry leaving cell 7 goes out of the tile, so a tile stacked above can continue the chain from it. A small selector sets the carry entering cell 0: a constant low, a constant high, or the carry arriving from the tile below.

The incoming carry of each cell also drives that cell's fourth LUT input. A LUT can therefore form a sum bit, or it can pass the carry value out of the chain into general logic. Two tricks bring an ordinary logic signal into the chain through a normal cell:
- Tie one operand low, force the carry-in high, and drive the signal on the other operand.
- Drive both operands with the same signal. The carry-in then has no effect on the result.

The tile is purely combinational. Tiles are cascaded by wiring one tile's carry output to the next tile's carry input.

Top module: `carry_tile`

## Requirements
- R1: Each cell's LUT output equals bit {I3,I2,I1,I0} of that cell's 16-bit truth table. The truth table of cell i is lut_cfg[16*i+15:16*i]. I0 is op_a[i], I1 is op_b[i], I2 is aux_in[i], and I3 is the cell's incoming carry.
- R2: A cell's carry-out is high when at least two of op_a[i], op_b[i] and its incoming carry are high.
- R3: Cell i (i>0) takes the carry-out of cell i-1 as its incoming carry, and cascade_out equals the carry-out of cell 7.
- R4: With cin_mode = 2'b00, the incoming carry of cell 0 is 0.
- R5: With cin_mode = 2'b01, the incoming carry of cell 0 is 1.
- R6: With cin_mode = 2'b10, the incoming carry of cell 0 equals cascade_in.
- R7: With the reserved cin_mode = 2'b11, the incoming carry of cell 0 is 0, whatever the value of cascade_in.
- R8: With cin_mode = 2'b01, op_b[0] = 0 and op_a[0] = x, the carry leaving cell 0 equals x.
- R9: With op_a[i] = op_b[i] = x, the carry leaving cell i equals x for either value of its incoming carry.
- R10: A cell whose truth table is 16'hFF00 outputs its incoming carry on lut_out[i].
- R11: Two tiles, each cell using truth table 16'h9966 (I0^I1^I3), with the lower tile in mode 00 and the upper tile in mode 10 fed from the lower tile's cascade_out, produce the 17-bit sum of two 16-bit operands on {upper cascade_out, upper lut_out, lower lut_out}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First carry operand per cell; LUT input I0 |
| op_b | input | 8 | Second carry operand per cell; LUT input I1 |
| aux_in | input | 8 | Extra LUT input I2 per cell |
| lut_cfg | input | 128 | Truth tables, 16 bits per cell, cell 0 in the low bits |
| cin_mode | input | 2 | Carry entry select: 00 zero, 01 one, 10 cascade, 11 reserved (zero) |
| cascade_in | input | 1 | Carry from the tile below |
| lut_out | output | 8 | LUT output per cell |
| cascade_out | output | 1 | Carry from cell 7 to the tile above |

## Verification
The assertions check on every input change that each LUT output matches its truth table. They also check the majority rule at every cell, the value entering cell 0 for all four selector codes, and same-operand injection. Only the bench scenarios can show end-to-end uses. These are a 16-bit addition across two stacked tiles, the tie-low feed-in observed through a pass-through LUT in the next cell, and a carry brought out mid-chain.

// File: rtl/tile_pkg.sv
package tile_pkg;

    localparam int unsigned CELLS      = 8;
    localparam int unsigned LUT_INPUTS = 4;
    localparam int unsigned LUT_BITS   = 1 << LUT_INPUTS;

    typedef enum logic [1:0] {
        CIN_ZERO    = 2'b00,
        CIN_ONE     = 2'b01,
        CIN_CASCADE = 2'b10,
        CIN_RSVD    = 2'b11
    } cin_mode_e;

    // LUT address, MSB first: {I3,I2,I1,I0}
    typedef struct packed {
        logic carry;
        logic aux;
        logic opb;
        logic opa;
    } lut_addr_t;

    function automatic logic majority3(input logic x, input logic y, input logic z);
        return (x & y) | (z & (x | y));
    endfunction

endpackage

// File: rtl/cin_select.sv
module cin_select
    import tile_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       from_below,
    output logic       chain_start
);
    cin_mode_e mode_e;

    always_comb begin
        mode_e = cin_mode_e'(mode);
        unique case (mode_e)
            CIN_ONE:     chain_start = 1'b1;
            CIN_CASCADE: chain_start = from_below;
            default:     chain_start = 1'b0;
        endcase
    end
endmodule

// File: rtl/lut_unit.sv
module lut_unit
    import tile_pkg::*;
#(
    parameter int unsigned K = LUT_INPUTS,
    localparam int unsigned DEPTH = 1 << K
) (
    input  logic [K-1:0]     addr,
    input  logic [DEPTH-1:0] table_bits,
    output logic             y
);
    assign y = table_bits[addr];
endmodule

// File: rtl/carry_unit.sv
module carry_unit
    import tile_pkg::*;
(
    input  logic opa,
    input  logic opb,
    input  logic cin,
    output logic cout
);
    assign cout = majority3(opa, opb, cin);
endmodule

// File: rtl/logic_cell.sv
module logic_cell
    import tile_pkg::*;
(
    input  logic                opa,
    input  logic                opb,
    input  logic                aux,
    input  logic                cin,
    input  logic [LUT_BITS-1:0] truth,
    output logic                lut_y,
    output logic                cout
);
    lut_addr_t addr;

    always_comb begin
        addr.carry = cin;
        addr.aux   = aux;
        addr.opb   = opb;
        addr.opa   = opa;
    end

    lut_unit #(.K(LUT_INPUTS)) u_lut (
        .addr       (addr),
        .table_bits (truth),
        .y          (lut_y)
    );

    carry_unit u_carry (
        .opa  (opa),
        .opb  (opb),
        .cin  (cin),
        .cout (cout)
    );
endmodule

// File: rtl/carry_tile.sv
module carry_tile
    import tile_pkg::*;
#(
    parameter int unsigned NUM_CELLS = CELLS,
    localparam int unsigned CFG_W = NUM_CELLS * LUT_BITS
) (
    input  logic [NUM_CELLS-1:0] op_a,
    input  logic [NUM_CELLS-1:0] op_b,
    input  logic [NUM_CELLS-1:0] aux_in,
    input  logic [CFG_W-1:0]     lut_cfg,
    input  logic [1:0]           cin_mode,
    input  logic                 cascade_in,
    output logic [NUM_CELLS-1:0] lut_out,
    output logic                 cascade_out
);
    // carry_chain[i] enters cell i; carry_chain[NUM_CELLS] leaves the tile
    logic [NUM_CELLS:0] carry_chain;

    cin_select u_sel (
        .mode        (cin_mode),
        .from_below  (cascade_in),
        .chain_start (carry_chain[0])
    );

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        logic_cell u_cell (
            .opa   (op_a[c]),
            .opb   (op_b[c]),
            .aux   (aux_in[c]),
            .cin   (carry_chain[c]),
            .truth (lut_cfg[c*LUT_BITS +: LUT_BITS]),
            .lut_y (lut_out[c]),
            .cout  (carry_chain[c+1])
        );
    end

    assign cascade_out = carry_chain[NUM_CELLS];
endmodule

// File: rtl/carry_tile_chk.sv
module carry_tile_chk
    import tile_pkg::*;
#(
    parameter int unsigned NUM_CELLS = CELLS,
    localparam int unsigned CFG_W = NUM_CELLS * LUT_BITS
) (
    input logic [NUM_CELLS-1:0] op_a,
    input logic [NUM_CELLS-1:0] op_b,
    input logic [NUM_CELLS-1:0] aux_in,
    input logic [CFG_W-1:0]     lut_cfg,
    input logic [1:0]           cin_mode,
    input logic                 cascade_in,
    input logic [NUM_CELLS-1:0] lut_out,
    input logic                 cascade_out,
    input logic [NUM_CELLS:0]   chain
);
    always_comb begin
        for (int i = 0; i < NUM_CELLS; i++) begin
            assert_lut_lookup_R1: assert (lut_out[i] ===
                lut_cfg[i*LUT_BITS + {chain[i], aux_in[i], op_b[i], op_a[i]}])
                else $error("R1 cell %0d LUT mismatch", i);
            assert_majority_R2: assert (chain[i+1] ===
                ($countones({op_a[i], op_b[i], chain[i]}) >= 2))
                else $error("R2 cell %0d carry mismatch", i);
            if (op_a[i] === op_b[i])
                assert_same_operand_R9: assert (chain[i+1] === op_a[i])
                    else $error("R9 cell %0d injection mismatch", i);
        end
        if (cin_mode == 2'b00)
            assert_entry_zero_R4: assert (chain[0] === 1'b0) else $error("R4");
        if (cin_mode == 2'b01)
            assert_entry_one_R5: assert (chain[0] === 1'b1) else $error("R5");
        if (cin_mode == 2'b10)
            assert_entry_cascade_R6: assert (chain[0] === cascade_in) else $error("R6");
        if (cin_mode == 2'b11)
            assert_entry_reserved_R7: assert (chain[0] === 1'b0) else $error("R7");
        assert_exit_R3: assert (cascade_out === chain[NUM_CELLS]) else $error("R3");
    end
endmodule

bind carry_tile carry_tile_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
    .op_a        (op_a),
    .op_b        (op_b),
    .aux_in      (aux_in),
    .lut_cfg     (lut_cfg),
    .cin_mode    (cin_mode),
    .cascade_in  (cascade_in),
    .lut_out     (lut_out),
    .cascade_out (cascade_out),
    .chain       (carry_chain)
);

// File: tb/sim_carry_tile.sv
module sim_carry_tile;

    localparam int N = 8;
    localparam logic [15:0] T_SUM  = 16'h9966;
    localparam logic [15:0] T_PASS = 16'hFF00;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]    a0, b0, x0, a1, b1, x1, y0, y1;
    logic [16*N-1:0] cfg0, cfg1;
    logic [1:0]      m0, m1;
    logic            cin0, co0, co1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    carry_tile u0 (
        .op_a(a0), .op_b(b0), .aux_in(x0), .lut_cfg(cfg0),
        .cin_mode(m0), .cascade_in(cin0), .lut_out(y0), .cascade_out(co0)
    );

    carry_tile u1 (
        .op_a(a1), .op_b(b1), .aux_in(x1), .lut_cfg(cfg1),
        .cin_mode(m1), .cascade_in(co0), .lut_out(y1), .cascade_out(co1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model of one tile: returns {carry out, lut outputs}
    function automatic logic [N:0] tile_ref(input logic [N-1:0] a, input logic [N-1:0] b,
                                             input logic [N-1:0] x, input logic [16*N-1:0] cfg,
                                             input logic [1:0] mode, input logic below);
        logic c;
        logic [N-1:0] y;
        c = (mode == 2'b01) ? 1'b1 : (mode == 2'b10) ? below : 1'b0;
        for (int i = 0; i < N; i++) begin
            y[i] = cfg[16*i + 8*c + 4*x[i] + 2*b[i] + a[i]];
            c = (int'(a[i]) + int'(b[i]) + int'(c)) > 1;
        end
        return {c, y};
    endfunction

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        a0 = '0; b0 = '0; x0 = '0; cfg0 = '0; m0 = 2'b00; cin0 = 1'b0;
        a1 = '0; b1 = '0; x1 = '0; cfg1 = '0; m1 = 2'b00;
        settle();
        check("R1 idle lut", 32'(y0), 32'h0);
        check("R4 idle cascade", 32'(co0), 32'h0);

        // Random single-tile vectors across all selector codes (R1 R2 R3 R4 R5 R6 R7)
        for (int k = 0; k < 200; k++) begin
            logic [N:0] exp;
            @(posedge clk);
            a0 = N'($urandom); b0 = N'($urandom); x0 = N'($urandom);
            for (int j = 0; j < N; j++) cfg0[16*j +: 16] = 16'($urandom);
            m0 = 2'($urandom); cin0 = 1'($urandom);
            settle();
            exp = tile_ref(a0, b0, x0, cfg0, m0, cin0);
            check("R1 random lut", 32'(y0), 32'(exp[N-1:0]));
            check("R2 R3 random carry out", 32'(co0), 32'(exp[N]));
        end

        // Selector directed cases, observed through pass-through LUT on cell 0 (R10)
        @(posedge clk);
        a0 = '0; b0 = '0; x0 = '0; cfg0 = {N{T_PASS}};
        m0 = 2'b01; cin0 = 1'b0;
        settle();
        check("R5 R10 const one", 32'(y0), 32'h01);
        @(posedge clk); m0 = 2'b10; cin0 = 1'b1; settle();
        check("R6 cascade high", 32'(y0[0]), 32'h1);
        @(posedge clk); cin0 = 1'b0; settle();
        check("R6 cascade low", 32'(y0[0]), 32'h0);
        @(posedge clk); m0 = 2'b11; cin0 = 1'b1; settle();
        check("R7 reserved ignores cascade", 32'(y0[0]), 32'h0);
        @(posedge clk); m0 = 2'b00; settle();
        check("R4 zero ignores cascade", 32'(y0[0]), 32'h0);

        // Feed-in with tied-low operand, seen on cell 1 pass-through (R8 R10)
        for (int v = 0; v < 2; v++) begin
            @(posedge clk);
            a0 = '0; b0 = '0; a0[0] = 1'(v); m0 = 2'b01;
            settle();
            check("R8 tie-low feed-in", 32'(y0[1]), 32'(v));
        end

        // Same-operand injection at cell 4, for both incoming carries (R9)
        for (int v = 0; v < 2; v++) begin
            for (int c = 0; c < 2; c++) begin
                @(posedge clk);
                a0 = '0; b0 = '0; m0 = c ? 2'b01 : 2'b00;
                a0[3:0] = c ? 4'hF : 4'h0; b0[3:0] = c ? 4'hF : 4'h0;
                a0[4] = 1'(v); b0[4] = 1'(v);
                settle();
                check("R9 incoming carry at cell4", 32'(y0[4]), 32'(c));
                check("R9 same-operand feed-in", 32'(y0[5]), 32'(v));
            end
        end

        // Two-tile 16-bit addition (R11)
        cfg0 = {N{T_SUM}}; cfg1 = {N{T_SUM}};
        m0 = 2'b00; m1 = 2'b10; x0 = '0; x1 = '0; cin0 = 1'b1;
        for (int k = 0; k < 300; k++) begin
            logic [15:0] p, q;
            logic [16:0] s;
            @(posedge clk);
            case (k)
                0: begin p = 16'hFFFF; q = 16'h0001; end
                1: begin p = 16'hFFFF; q = 16'hFFFF; end
                2: begin p = 16'h0000; q = 16'h0000; end
                3: begin p = 16'h00FF; q = 16'h0001; end
                default: begin p = 16'($urandom); q = 16'($urandom); end
            endcase
            {a1, a0} = p; {b1, b0} = q;
            x0 = N'($urandom); x1 = N'($urandom);
            x0 = '0; x1 = '0;
            settle();
            s = {1'b0, p} + {1'b0, q};
            check("R11 two-tile sum", 32'({co1, y1, y0}), 32'(s));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule